// File: doc/BRIEF.md
# Programmable Set Membership Matcher

This block answers one question per query: does an unsigned integer belong to a set that software-side logic has loaded into it? The set holds a fixed number of slots. Each slot is either a single value or an inclusive interval described by a lower and an upper bound. Each slot also has its own enable bit. Slots are loaded one at a time through a write port that carries the slot number, the slot kind, both bounds and the enable.

A query is presented with a valid strobe. In the next cycle the block raises a result-valid flag. It also returns three results: an "inside" flag, its complement the "outside" flag, and a vector with one bit per slot marking every slot the query hit. Slots may overlap or repeat values freely. An interval whose lower bound exceeds its upper bound is legal and is simply empty.

Top module: `setm_matcher`

## Requirements
- R1: A single-value slot (kind bit 0) hits only when the query equals its lower-bound field. Its upper-bound field is ignored.
- R2: An interval slot (kind bit 1) hits for every query from its lower bound through its upper bound. Both ends are included.
- R3: An interval slot whose lower bound is greater than its upper bound never hits, whatever the query.
- R4: Overlapping or repeated slots are allowed. Every slot that covers the query sets its own bit in `res_hits`, and `res_inside` is 1.
- R5: `res_outside` is always the exact complement of `res_inside`, including during and after reset.
- R6: A slot whose enable is 0 never hits. After reset every slot is disabled, so no query matches. During reset, `res_valid`=0, `res_inside`=0, `res_outside`=1 and `res_hits`=0.
- R7: `res_valid` is 1 exactly in the cycle after a cycle with `q_valid`=1. Results change only on such queries and hold otherwise.
- R8: A write performed in the same cycle as a query does not affect that query. It only affects later queries.
- R9: `res_inside` equals the OR of all bits of `res_hits`. Bit i of `res_hits` belongs to slot i.
- R10: All bounds and queries are unsigned. A query with the top bit set compares above every smaller value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe for one slot |
| wr_index | input | IDXW | Slot number to write |
| wr_kind | input | 1 | 0 = single value, 1 = interval |
| wr_enable | input | 1 | Enable bit stored with the slot |
| wr_lo | input | WIDTH | Value, or lower bound |
| wr_hi | input | WIDTH | Upper bound (intervals only) |
| q_valid | input | 1 | Query strobe |
| q_data | input | WIDTH | Query value |
| res_valid | output | 1 | Result present (one cycle after query) |
| res_inside | output | 1 | Query is a member of the set |
| res_outside | output | 1 | Query is not a member of the set |
| res_hits | output | ENTRIES | One bit per slot that covered the query |

## Verification
The bench probes interval edges exactly at the lower bound, at the upper bound and one step beyond each. A design that used strict comparisons would drop an end value, and one that was off by one would accept a neighbour. It loads an inverted interval and queries both of its bounds and a value between them. A design that did not treat such an interval as empty would report a match there. It issues a write and a query to the same slot in the same cycle. A design that forwarded the write would report the new contents one query too early. It also places a wide interval across the top bit, where a signed compare would reject large queries. Random loads of overlapping slots check the per-slot vector against a bench model, which exposes any single-winner priority encoding.

// File: rtl/setm_pkg.sv
package setm_pkg;

    typedef enum logic {
        KIND_SINGLE   = 1'b0,
        KIND_INTERVAL = 1'b1
    } slot_kind_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/setm_slot.sv
module setm_slot
    import setm_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_kind,
    input  logic             load_enable,
    input  logic [WIDTH-1:0] load_lo,
    input  logic [WIDTH-1:0] load_hi,
    input  logic [WIDTH-1:0] probe,
    output logic             hit
);

    typedef struct packed {
        logic             enabled;
        slot_kind_e       kind;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] hi;
    } slot_t;

    slot_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q.enabled <= load_enable;
            state_q.kind    <= slot_kind_e'(load_kind);
            state_q.lo      <= load_lo;
            state_q.hi      <= load_hi;
        end
    end

    logic eq_lo;
    logic ge_lo;
    logic le_hi;

    always_comb begin
        eq_lo = (probe == state_q.lo);
        ge_lo = (probe >= state_q.lo);
        le_hi = (probe <= state_q.hi);
        hit   = 1'b0;
        if (state_q.enabled) begin
            case (state_q.kind)
                KIND_SINGLE:   hit = eq_lo;
                KIND_INTERVAL: hit = ge_lo && le_hi;
                default:       hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/setm_result.sv
module setm_result #(
    parameter int unsigned ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  logic [ENTRIES-1:0] hits_now,
    output logic               res_valid,
    output logic               res_inside,
    output logic               res_outside,
    output logic [ENTRIES-1:0] res_hits
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_inside  <= 1'b0;
            res_outside <= 1'b1;
            res_hits    <= '0;
        end else begin
            res_valid <= take;
            if (take) begin
                res_hits    <= hits_now;
                res_inside  <= |hits_now;
                res_outside <= ~(|hits_now);
            end
        end
    end

endmodule

// File: rtl/setm_matcher.sv
module setm_matcher
    import setm_pkg::*;
#(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDXW   = idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_valid,
    input  logic [IDXW-1:0]    wr_index,
    input  logic               wr_kind,
    input  logic               wr_enable,
    input  logic [WIDTH-1:0]   wr_lo,
    input  logic [WIDTH-1:0]   wr_hi,
    input  logic               q_valid,
    input  logic [WIDTH-1:0]   q_data,
    output logic               res_valid,
    output logic               res_inside,
    output logic               res_outside,
    output logic [ENTRIES-1:0] res_hits
);

    logic [ENTRIES-1:0] hits_now;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = wr_valid && (wr_index == IDXW'(g));
        setm_slot #(.WIDTH(WIDTH)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .load        (sel),
            .load_kind   (wr_kind),
            .load_enable (wr_enable),
            .load_lo     (wr_lo),
            .load_hi     (wr_hi),
            .probe       (q_data),
            .hit         (hits_now[g])
        );
    end

    setm_result #(.ENTRIES(ENTRIES)) u_result (
        .clk         (clk),
        .rst         (rst),
        .take        (q_valid),
        .hits_now    (hits_now),
        .res_valid   (res_valid),
        .res_inside  (res_inside),
        .res_outside (res_outside),
        .res_hits    (res_hits)
    );

endmodule

// File: rtl/setm_matcher_chk.sv
module setm_matcher_chk #(
    parameter int unsigned ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               q_valid,
    input logic               res_valid,
    input logic               res_inside,
    input logic               res_outside,
    input logic [ENTRIES-1:0] res_hits
);

    AST_OUTSIDE_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        res_outside == !res_inside); // R5

    AST_INSIDE_IS_ANY_HIT: assert property (@(posedge clk) disable iff (rst)
        res_inside == (res_hits != '0)); // R9

    AST_RESULT_FOLLOWS_QUERY: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> res_valid); // R7

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> !res_valid); // R7

    AST_HITS_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> $stable(res_hits)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!res_valid && res_hits == '0 && res_outside)); // R6

endmodule

bind setm_matcher setm_matcher_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .q_valid     (q_valid),
    .res_valid   (res_valid),
    .res_inside  (res_inside),
    .res_outside (res_outside),
    .res_hits    (res_hits)
);

// File: tb/sim_setm_matcher.sv
`timescale 1ns/1ps
module sim_setm_matcher;

    localparam int W = 16;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid;
    logic [IW-1:0] wr_index;
    logic          wr_kind;
    logic          wr_enable;
    logic [W-1:0]  wr_lo;
    logic [W-1:0]  wr_hi;
    logic          q_valid;
    logic [W-1:0]  q_data;
    logic          res_valid;
    logic          res_inside;
    logic          res_outside;
    logic [N-1:0]  res_hits;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic         m_en   [N];
    logic         m_kind [N];
    logic [W-1:0] m_lo   [N];
    logic [W-1:0] m_hi   [N];

    always #10 clk = ~clk;

    setm_matcher #(.WIDTH(W), .ENTRIES(N)) u0 (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_index(wr_index), .wr_kind(wr_kind),
        .wr_enable(wr_enable), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .q_valid(q_valid), .q_data(q_data),
        .res_valid(res_valid), .res_inside(res_inside),
        .res_outside(res_outside), .res_hits(res_hits)
    );

    function automatic logic [N-1:0] model_hits(input logic [W-1:0] q);
        logic [N-1:0] h = '0;
        for (int i = 0; i < N; i++) begin
            if (m_en[i]) begin
                if (m_kind[i] == 1'b0) h[i] = (q == m_lo[i]);
                else h[i] = (m_lo[i] <= m_hi[i]) && (q >= m_lo[i]) && (q <= m_hi[i]);
            end
        end
        return h;
    endfunction

    task automatic compare(input string tag, input logic [N-1:0] exp_h);
        logic [N+2:0] act;
        logic [N+2:0] exp;
        act = {res_valid, res_inside, res_outside, res_hits};
        exp = {1'b1, |exp_h, ~|exp_h, exp_h};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,in,out,hits} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_wr(input int idx, input logic kind, input logic en,
                          input logic [W-1:0] lo, input logic [W-1:0] hi);
        wr_valid = 1'b1; wr_index = IW'(idx); wr_kind = kind;
        wr_enable = en; wr_lo = lo; wr_hi = hi;
    endtask

    task automatic commit(input int idx, input logic kind, input logic en,
                          input logic [W-1:0] lo, input logic [W-1:0] hi);
        m_en[idx] = en; m_kind[idx] = kind; m_lo[idx] = lo; m_hi[idx] = hi;
    endtask

    task automatic load(input int idx, input logic kind, input logic en,
                        input logic [W-1:0] lo, input logic [W-1:0] hi);
        @(negedge clk);
        set_wr(idx, kind, en, lo, hi);
        @(negedge clk);
        wr_valid = 1'b0;
        commit(idx, kind, en, lo, hi);
    endtask

    task automatic ask(input string tag, input logic [W-1:0] q);
        logic [N-1:0] e;
        @(negedge clk);
        q_valid = 1'b1; q_data = q;
        e = model_hits(q);
        @(negedge clk);
        q_valid = 1'b0;
        compare(tag, e);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] e;
        logic [N-1:0] held;
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) commit(i, 1'b0, 1'b0, '0, '0);
        rst = 1'b1; wr_valid = 1'b0; wr_index = '0; wr_kind = 1'b0;
        wr_enable = 1'b0; wr_lo = '0; wr_hi = '0; q_valid = 1'b0; q_data = '0;
        repeat (3) @(negedge clk);
        checks++;
        if ({res_valid, res_inside, res_outside, res_hits} !== {3'b001, {N{1'b0}}}) begin
            errors++;
            $display("FAIL R6 reset: actual=%b expected=%b",
                     {res_valid, res_inside, res_outside, res_hits}, {3'b001, {N{1'b0}}});
        end
        rst = 1'b0;

        ask("R6 empty set", 16'd0);
        ask("R6 empty set", 16'd5);

        load(0, 1'b0, 1'b1, 16'd5, 16'd900);
        ask("R1 single eq", 16'd5);
        ask("R1 single below", 16'd4);
        ask("R1 single above / hi ignored", 16'd6);
        ask("R1 hi field ignored", 16'd900);

        load(1, 1'b1, 1'b1, 16'd10, 16'd20);
        ask("R2 low end", 16'd10);
        ask("R2 high end", 16'd20);
        ask("R2 below low", 16'd9);
        ask("R2 above high", 16'd21);

        load(2, 1'b1, 1'b1, 16'd30, 16'd25);
        ask("R3 empty at lo", 16'd30);
        ask("R3 empty at hi", 16'd25);
        ask("R3 empty mid", 16'd27);

        load(3, 1'b1, 1'b1, 16'd15, 16'd18);
        load(5, 1'b0, 1'b1, 16'd16, 16'd0);
        ask("R4 overlap", 16'd16);
        ask("R4 overlap edge", 16'd18);

        load(4, 1'b1, 1'b1, 16'h0010, 16'hFFF0);
        ask("R10 top bit inside", 16'h8000);
        ask("R10 above high", 16'hFFFF);
        ask("R10 below low", 16'h000F);

        load(4, 1'b1, 1'b0, 16'h0010, 16'hFFF0);
        ask("R6 disabled slot", 16'h8000);

        @(negedge clk);
        set_wr(0, 1'b0, 1'b1, 16'd100, 16'd0);
        q_valid = 1'b1; q_data = 16'd100;
        e = model_hits(16'd100);
        @(negedge clk);
        wr_valid = 1'b0; q_valid = 1'b0;
        commit(0, 1'b0, 1'b1, 16'd100, 16'd0);
        compare("R8 same-cycle write", e);
        ask("R8 later query", 16'd100);
        ask("R8 old value gone", 16'd5);

        ask("R7 prime", 16'd16);
        held = res_hits;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_hits !== held) begin
            errors++;
            $display("FAIL R7 idle: actual=%b/%b expected=0/%b", res_valid, res_hits, held);
        end

        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [W-1:0] a;
                logic [W-1:0] b;
                a = W'($urandom_range(0, 63));
                b = W'($urandom_range(0, 63));
                load(int'($urandom_range(0, N - 1)), 1'($urandom_range(0, 1)),
                     ($urandom_range(0, 4) != 0), a, b);
            end else begin
                ask("R4 R5 R9 random", W'($urandom_range(0, 70)));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule